// File: doc/BRIEF.md
# Exponent-Mantissa Audio Gain Stage with Soft Mute

This block scales a stream of signed 24-bit audio samples by a programmable gain. The gain arrives as a 13-bit code split into a 5-bit exponent and an 8-bit mantissa. The effective factor is `mantissa / 256 × 2^(exponent − 16)`, so the code space covers very small attenuations as well as large boosts. Each sample presented with its valid strobe comes back one clock later, scaled, rounded to nearest and clipped to the 24-bit signed range.

The gain is never switched in one step. The block keeps an applied gain and moves it toward the programmed target by a fixed linear step once per accepted sample. Writing the all-zero code starts a soft mute: the target drops to zero and the output fades out over successive samples. While muted, the only code that releases the mute is the last non-zero code that was in force before muting. Writing it restores that target, and the output ramps up again from silence. Any other non-zero code written during mute is discarded.

Top module: `expgain_mute`

## Requirements
- R1: After reset, out_valid is 0 and out_sample is 0, and the applied gain is exactly unity (code exponent 17, mantissa 0x80), so samples pass through unchanged.
- R2: gain_code[12:8] is the exponent and gain_code[7:0] the mantissa. The target gain is mantissa × 2^exponent / 2^24.
- R3: An in_valid cycle produces out_valid high on the next cycle only. A cycle without in_valid gives out_valid low on the next cycle, and out_sample keeps its value.
- R4: The output is floor(sample × gain + 1/2), so exact halves round toward plus infinity (1.5 to 2, −1.5 to −1, −0.5 to 0).
- R5: Results above 8388607 give 8388607, and results below −8388608 give −8388608.
- R6: Each accepted sample is scaled by the applied gain in force before that sample. The applied gain then moves toward the target by 2^STEP_LOG2 / 2^24 (1/64 by default), landing exactly on the target when the remaining distance is no larger than one step. Without samples, the applied gain does not change.
- R7: Writing gain_code 0 enters mute and sets the target to zero, so the output ramps down to silence.
- R8: While muted, writing a non-zero code that differs from the last non-zero code before muting has no effect: the target stays zero and the output stays silent.
- R9: While muted, writing the last non-zero code from before muting leaves mute. The applied gain ramps up from its present value toward that code's gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 24 | Signed input sample |
| gain_load | input | 1 | Gain code load strobe |
| gain_code | input | 13 | Gain code: exponent in bits 12:8, mantissa in bits 7:0 |
| out_valid | output | 1 | Output sample strobe, one cycle after in_valid |
| out_sample | output | 24 | Scaled, rounded, saturated signed sample |

## Verification
Runs of samples pass through the unity reset gain, a descending ramp to one half, and an ascending ramp to two. Every output is compared sample by sample with a step model, which separates gain-before-step from gain-after-step ordering and overshoot at the end of a ramp. Small odd values of both signs at gain one half tell round-half-up apart from truncation and from round-half-away-from-zero. Full-scale values at gain two expose clipping on each side. A fade to silence, a rejected foreign code, and a release by the saved code show whether the mute ignores the wrong code and restarts from zero.

// File: rtl/expgain_pkg.sv
package expgain_pkg;

  // Direction in which the applied gain is travelling this sample.
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } ramp_dir_e;

endpackage

// File: rtl/expgain_ctrl.sv
// Holds the gain target, the mute flag and the last non-zero code.
module expgain_ctrl #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 8,
  parameter logic [EXP_W+MAN_W-1:0] RST_CODE = 13'h1180
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   load,
  input  logic [EXP_W+MAN_W-1:0]                 code,
  output logic [MAN_W+(1<<EXP_W)-2:0]            tgt_o,
  output logic                                   muted_o,
  output logic [EXP_W+MAN_W-1:0]                 saved_o
);

  localparam int CW = EXP_W + MAN_W;
  localparam int GW = MAN_W + (1 << EXP_W) - 1;
  localparam logic [GW-1:0] RST_LIN =
    GW'(RST_CODE[MAN_W-1:0]) << RST_CODE[CW-1:MAN_W];

  logic [GW-1:0] tgt_q, tgt_d, code_lin;
  logic          muted_q, muted_d;
  logic [CW-1:0] sav_q, sav_d;
  logic          code_zero;

  always_comb begin
    code_lin  = GW'(code[MAN_W-1:0]) << code[CW-1:MAN_W];
    code_zero = (code == '0);
  end

  always_comb begin
    tgt_d   = tgt_q;
    muted_d = muted_q;
    sav_d   = sav_q;
    if (load) begin
      if (code_zero) begin
        muted_d = 1'b1;
        tgt_d   = '0;
      end else if (!muted_q) begin
        sav_d = code;
        tgt_d = code_lin;
      end else if (code == sav_q) begin
        muted_d = 1'b0;
        tgt_d   = code_lin;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= RST_LIN;
      muted_q <= 1'b0;
      sav_q   <= RST_CODE;
    end else if (load) begin
      tgt_q   <= tgt_d;
      muted_q <= muted_d;
      sav_q   <= sav_d;
    end
  end

  assign tgt_o   = tgt_q;
  assign muted_o = muted_q;
  assign saved_o = sav_q;

endmodule

// File: rtl/expgain_ramp.sv
// Moves the applied linear gain toward the target, one step per sample.
module expgain_ramp
  import expgain_pkg::*;
#(
  parameter int GW = 39,
  parameter int STEP_LOG2 = 18,
  parameter logic [GW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [GW-1:0] tgt,
  output logic [GW-1:0] gain_o
);

  localparam logic [GW-1:0] STEP = GW'(1) << STEP_LOG2;

  logic [GW-1:0] g_q, g_d, gap;
  ramp_dir_e     dir;

  always_comb begin
    if (g_q < tgt) begin
      dir = DIR_UP;
      gap = tgt - g_q;
    end else if (g_q > tgt) begin
      dir = DIR_DOWN;
      gap = g_q - tgt;
    end else begin
      dir = DIR_HOLD;
      gap = '0;
    end
  end

  always_comb begin
    unique case (dir)
      DIR_UP:   g_d = (gap <= STEP) ? tgt : g_q + STEP;
      DIR_DOWN: g_d = (gap <= STEP) ? tgt : g_q - STEP;
      default:  g_d = g_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   g_q <= RST_VAL;
    else if (adv) g_q <= g_d;
  end

  assign gain_o = g_q;

endmodule

// File: rtl/expgain_scale.sv
// Multiplies, rounds half up and clips; one register stage.
module expgain_scale #(
  parameter int DW   = 24,
  parameter int GW   = 39,
  parameter int FRAC = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  input  logic [GW-1:0] gain,
  output logic          out_valid,
  output logic [DW-1:0] out_sample
);

  localparam int PW = DW + GW + 1;
  localparam logic signed [PW-1:0] MAXV = (PW'(1) << (DW - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = ~MAXV;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);

  logic signed [PW-1:0] a_ext, b_ext, prod, rnd, shifted;
  logic        [DW-1:0] clip_d;
  logic                 vld_q;
  logic        [DW-1:0] smp_q;

  always_comb begin
    a_ext   = {{(GW + 1){in_sample[DW-1]}}, in_sample};
    b_ext   = {{(DW + 1){1'b0}}, gain};
    prod    = a_ext * b_ext;
    rnd     = prod + HALF;
    shifted = rnd >>> FRAC;
    if (shifted > MAXV)      clip_d = MAXV[DW-1:0];
    else if (shifted < MINV) clip_d = MINV[DW-1:0];
    else                     clip_d = shifted[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        smp_q <= '0;
    else if (in_valid) smp_q <= clip_d;
  end

  assign out_valid  = vld_q;
  assign out_sample = smp_q;

endmodule

// File: rtl/expgain_mute.sv
module expgain_mute #(
  parameter int DATA_W    = 24,
  parameter int EXP_W     = 5,
  parameter int MAN_W     = 8,
  parameter int STEP_LOG2 = 18,
  parameter int SYNC_N    = 2,
  parameter logic [EXP_W+MAN_W-1:0] RST_CODE = 13'h1180
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [DATA_W-1:0]      in_sample,
  input  logic                   gain_load,
  input  logic [EXP_W+MAN_W-1:0] gain_code,
  output logic                   out_valid,
  output logic [DATA_W-1:0]      out_sample
);

  localparam int CW   = EXP_W + MAN_W;
  localparam int GW   = MAN_W + (1 << EXP_W) - 1;
  localparam int FRAC = MAN_W + (1 << (EXP_W - 1));
  localparam logic [GW-1:0] RST_LIN =
    GW'(RST_CODE[MAN_W-1:0]) << RST_CODE[CW-1:MAN_W];

  // Reset: asserted at once, released on a clock edge.
  logic [SYNC_N-1:0] sync_q;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_N-1];

  logic [GW-1:0] tgt, g_cur;
  logic          muted;
  logic [CW-1:0] saved;

  expgain_ctrl #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .RST_CODE(RST_CODE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .load(gain_load), .code(gain_code),
    .tgt_o(tgt), .muted_o(muted), .saved_o(saved)
  );

  expgain_ramp #(
    .GW(GW), .STEP_LOG2(STEP_LOG2), .RST_VAL(RST_LIN)
  ) u_ramp (
    .clk(clk), .rst_n(rst_sync_n), .adv(in_valid), .tgt(tgt), .gain_o(g_cur)
  );

  expgain_scale #(
    .DW(DATA_W), .GW(GW), .FRAC(FRAC)
  ) u_scale (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_sample(in_sample),
    .gain(g_cur), .out_valid(out_valid), .out_sample(out_sample)
  );

endmodule

// File: rtl/expgain_mute_chk.sv
module expgain_mute_chk #(
  parameter int GW = 39,
  parameter int CW = 13,
  parameter int DW = 24,
  parameter int STEP_LOG2 = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          gain_load,
  input logic [CW-1:0] gain_code,
  input logic          out_valid,
  input logic [DW-1:0] out_sample,
  input logic [GW-1:0] g_cur,
  input logic [GW-1:0] tgt,
  input logic          muted,
  input logic [CW-1:0] saved
);

  localparam logic [GW-1:0] STEP = GW'(1) << STEP_LOG2;

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R3
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sample)));

  // R6
  gain_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(g_cur));

  // R6
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((g_cur >= $past(g_cur)) ? (g_cur - $past(g_cur))
                                           : ($past(g_cur) - g_cur)) <= STEP));

  // R6
  settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_cur == tgt && !gain_load) |=> (g_cur == tgt));

  // R7
  mute_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_load && gain_code == '0) |=> (muted && tgt == '0));

  // R8
  foreign_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && gain_load && gain_code != '0 && gain_code != saved)
      |=> (muted && tgt == '0));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && gain_load && gain_code != '0 && gain_code == saved) |=> !muted);

endmodule

bind expgain_mute expgain_mute_chk #(
  .GW(GW), .CW(CW), .DW(DATA_W), .STEP_LOG2(STEP_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .gain_load(gain_load),
  .gain_code(gain_code), .out_valid(out_valid), .out_sample(out_sample),
  .g_cur(g_cur), .tgt(tgt), .muted(muted), .saved(saved)
);

// File: tb/sim_expgain_mute.sv
`timescale 1ns/1ps
module sim_expgain_mute;

  localparam longint STEP = 64'sd1 <<< 18;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_sample;
  logic        gain_load;
  logic [12:0] gain_code;
  logic        out_valid;
  logic [23:0] out_sample;

  int n_run  = 0;
  int n_fail = 0;

  // Bench-side model of the requirements.
  longint      m_g;
  longint      m_t;
  bit          m_mute;
  logic [12:0] m_sav;

  expgain_mute u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .gain_load(gain_load), .gain_code(gain_code),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic longint lin_of(input logic [12:0] c);
    return longint'(c[7:0]) <<< c[12:8];
  endfunction

  function automatic logic [23:0] expect_of(input int s, input longint g);
    longint p;
    p = longint'(s) * g;
    p = (p + (64'sd1 <<< 23)) >>> 24;
    if (p > 64'sd8388607)  p = 64'sd8388607;
    if (p < -64'sd8388608) p = -64'sd8388608;
    return p[23:0];
  endfunction

  task automatic check(input bit ok, input string req,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    if (m_g < m_t)      m_g = (m_t - m_g <= STEP) ? m_t : m_g + STEP;
    else if (m_g > m_t) m_g = (m_g - m_t <= STEP) ? m_t : m_g - STEP;
  endtask

  task automatic send(input int s, input string req);
    logic [23:0] e;
    e = expect_of(s, m_g);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = s[23:0];
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, req, longint'(out_valid), 1);
    check(out_sample == e, req, longint'(signed'(out_sample)), longint'(signed'(e)));
    model_step();
  endtask

  task automatic load(input logic [12:0] c);
    @(negedge clk);
    gain_load = 1'b1;
    gain_code = c;
    @(negedge clk);
    gain_load = 1'b0;
    if (c == 13'd0) begin
      m_mute = 1'b1;
      m_t    = 0;
    end else if (!m_mute) begin
      m_sav = c;
      m_t   = lin_of(c);
    end else if (c == m_sav) begin
      m_mute = 1'b0;
      m_t    = lin_of(c);
    end
  endtask

  task automatic t_reset();
    in_valid = 0; in_sample = '0; gain_load = 0; gain_code = '0;
    rst_n = 1'b0;
    m_g = 64'sd1 <<< 24; m_t = m_g; m_mute = 0; m_sav = 13'h1180;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
    check(out_sample == 24'd0, "R1 sample", longint'(out_sample), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after release", longint'(out_valid), 0);
  endtask

  task automatic t_unity();
    int vals[5] = '{1, -1, 8388607, -8388608, 123456};
    foreach (vals[i]) begin
      send(vals[i], "R1 unity");
      check(out_sample == vals[i][23:0], "R1 unchanged",
            longint'(signed'(out_sample)), longint'(vals[i]));
    end
  endtask

  task automatic t_ramp_half();
    // R2: exponent 16, mantissa 0x80 -> 0.5; R6 descending ramp
    load({5'd16, 8'h80});
    for (int i = 0; i < 40; i++) send(4000000, "R6 ramp down");
    check(m_g == (64'sd1 <<< 23), "R2 settled 0.5", m_g, 64'sd1 <<< 23);
  endtask

  task automatic t_round();
    send(3,  "R4 +1.5");
    check(out_sample == 24'd2, "R4 +1.5 up", longint'(signed'(out_sample)), 2);
    send(-3, "R4 -1.5");
    check(out_sample == 24'hFFFFFF, "R4 -1.5 up", longint'(signed'(out_sample)), -1);
    send(-1, "R4 -0.5");
    check(out_sample == 24'd0, "R4 -0.5 up", longint'(signed'(out_sample)), 0);
    send(1,  "R4 +0.5");
  endtask

  task automatic t_sat();
    // R2: exponent 18, mantissa 0x80 -> 2.0; R6 ascending ramp
    load({5'd18, 8'h80});
    for (int i = 0; i < 100; i++) send(-2000000, "R6 ramp up");
    send(6291456, "R5 high");
    check(out_sample == 24'h7FFFFF, "R5 high clip", longint'(signed'(out_sample)), 8388607);
    send(-6291456, "R5 low");
    check(out_sample == 24'h800000, "R5 low clip", longint'(signed'(out_sample)), -8388608);
  endtask

  task automatic t_idle();
    logic [23:0] last;
    send(1000, "R3 pulse");
    last = out_sample;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R3 idle valid", longint'(out_valid), 0);
    check(out_sample == last, "R3 idle hold", longint'(out_sample), longint'(last));
    send(1000, "R6 no drift while idle");
  endtask

  task automatic t_mute();
    load(13'd0);
    for (int i = 0; i < 135; i++) send(3000000, "R7 fade");
    send(8388607, "R7 silent");
    check(out_sample == 24'd0, "R7 silence", longint'(signed'(out_sample)), 0);
  endtask

  task automatic t_foreign();
    load({5'd17, 8'h80});
    for (int i = 0; i < 4; i++) begin
      send(8388607, "R8 ignored");
      check(out_sample == 24'd0, "R8 still muted", longint'(signed'(out_sample)), 0);
    end
  endtask

  task automatic t_release();
    load({5'd18, 8'h80});
    send(5000000, "R9 first after release");
    check(out_sample == 24'd0, "R9 starts at zero", longint'(signed'(out_sample)), 0);
    send(5000000, "R9 one step");
    check(out_sample == 24'd78125, "R9 one step up", longint'(signed'(out_sample)), 78125);
    for (int i = 0; i < 130; i++) send(-1500000, "R9 ramp up");
    send(-1500000, "R9 settled");
    check(out_sample == 24'(-3000000), "R9 full gain", longint'(signed'(out_sample)), -3000000);
  endtask

  initial begin
    t_reset();
    t_unity();
    t_ramp_half();
    t_round();
    t_sat();
    t_idle();
    t_mute();
    t_foreign();
    t_release();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog all actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule